// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a small 32-bit load/store processor in which every instruction is broken into one-clock phases. It receives the 6-bit opcode (instruction bits 31..26) and the 6-bit function code (instruction bits 5..0) from an instruction register held outside the block. Every cycle it drives the strobes and multiplexer selects of an external datapath. That datapath has one shared ALU, used both for the PC update and for execution, and one memory port, used both for fetch and for data access.

Each instruction class runs a different number of phases. Jumps and conditional branches take three. Register-register operations and stores take four. Loads take five. Any opcode the block does not decode uses two. The external datapath builds the jump target, which is instruction bits 25..0 shifted left by two and joined with PC bits 31..28. It also builds the sign-extended immediate, and it qualifies the conditional PC write with its own equality result.

The states and their transitions are as follows:
- FETCH always moves to DECODE.
- DECODE moves to REXEC for register-register, to ADDR for load or store, to BRANCH for branch-if-equal and to JUMP for jump. For any other opcode it moves back to FETCH.
- ADDR moves to MEMRD for a load and to MEMWR for a store.
- MEMRD moves to MEMWB.
- REXEC moves to RWB.
- MEMWB, MEMWR, RWB, BRANCH and JUMP all return to FETCH.
- A synchronous reset forces FETCH.

Top module: `mcs_ctrl_seq`

## Requirements
- R1: While `rst` is high, pc_wr, pc_wr_cond, mem_rd, mem_wr, ir_wr and reg_wr are all 0. The first cycle after `rst` falls is a fetch cycle.
- R2: A fetch cycle drives the following values:
  - mem_rd=1, ir_wr=1 and pc_wr=1.
  - addr_sel_data=0, which selects the PC as the memory address.
  - alu_a_sel=0 (PC) and alu_b_sel=01 (constant 4).
  - alu_ctl=010 (add) and pc_src=00 (ALU result).
- R3: The cycle after a fetch is a decode cycle. In it, no strobe is asserted, alu_a_sel=0, alu_b_sel=11 (immediate shifted left by two) and alu_ctl=010.
- R4: Load (opcode 0x23) takes 5 cycles:
  - Cycle 3: alu_a_sel=1 (register A), alu_b_sel=10 (sign-extended immediate), alu_ctl=010.
  - Cycle 4: mem_rd=1 with addr_sel_data=1.
  - Cycle 5: reg_wr=1, wb_sel_mem=1 and dst_sel_rd=0 (register named by bits 20..16).
- R5: Store (opcode 0x2B) takes 4 cycles. Cycle 3 is the same address phase as for a load. Cycle 4 has mem_wr=1 with addr_sel_data=1.
- R6: Register-register (opcode 0x00) takes 4 cycles:
  - Cycle 3: alu_a_sel=1, alu_b_sel=00 (register B), and alu_ctl decoded from the function code.
  - Cycle 4: reg_wr=1, wb_sel_mem=0 and dst_sel_rd=1 (register named by bits 15..11).
- R7: In the execute cycle of a register-register instruction, the function code maps to alu_ctl as follows:
  - 0x20 gives 010 (add).
  - 0x22 gives 110 (subtract).
  - 0x24 gives 000 (and).
  - 0x25 gives 001 (or).
  - 0x2A gives 111 (set-less-than).
  - Any other code gives 010.
- R8: Branch-if-equal (opcode 0x04) takes 3 cycles. Its third cycle drives pc_wr_cond=1, pc_wr=0, pc_src=01 (branch target register), alu_a_sel=1, alu_b_sel=00 and alu_ctl=110.
- R9: Jump (opcode 0x02) takes 3 cycles. Its third cycle drives pc_wr=1 and pc_src=10 (jump target), and asserts no other strobe.
- R10: Any other opcode returns to fetch right after decode. The PC, the registers and memory are not written in between.
- R11: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_opcode | input | 6 | Opcode field of the held instruction |
| ir_funct | input | 6 | Function code field of the held instruction |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the datapath's equality result |
| addr_sel_data | output | 1 | Memory address source: 0 = PC, 1 = ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| dst_sel_rd | output | 1 | Destination register: 0 = bits 20..16, 1 = bits 15..11 |
| wb_sel_mem | output | 1 | Write-back data: 0 = ALU output register, 1 = memory data register |
| reg_wr | output | 1 | Register file write |
| alu_a_sel | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted left by two |
| alu_ctl | output | 3 | ALU operation code |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |

## Verification
A wrong state register shows up at the ports within one cycle. The affected cycle drives the strobe pattern of another phase. For example, a second instruction-register load may appear where decode should be, or a write-back may fall on the wrong phase. An instruction may also last too many or too few cycles, and the next fetch then arrives one cycle early or late. Every phase of every instruction is compared against the expected strobe vector in the same cycle, so a misroute is caught in the phase where it first appears. An operation that is lost or repeated is caught no later than the next fetch.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADDR,
        ST_MEMRD,
        ST_MEMWR,
        ST_MEMWB,
        ST_REXEC,
        ST_RWB,
        ST_BRANCH,
        ST_JUMP
    } mcs_state_e;

    typedef enum logic [2:0] {
        CL_REG,
        CL_LOAD,
        CL_STORE,
        CL_BEQ,
        CL_JUMP,
        CL_BAD
    } mcs_class_e;

    typedef enum logic [1:0] {
        AOP_ADD  = 2'b00,
        AOP_SUB  = 2'b01,
        AOP_FUNC = 2'b10,
        AOP_RSVD = 2'b11
    } mcs_aluop_e;

    localparam logic [1:0] SRCB_REG  = 2'b00;
    localparam logic [1:0] SRCB_FOUR = 2'b01;
    localparam logic [1:0] SRCB_IMM  = 2'b10;
    localparam logic [1:0] SRCB_IMM4 = 2'b11;

    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_AOUT = 2'b01;
    localparam logic [1:0] PCS_JUMP = 2'b10;

    localparam logic [2:0] CTL_AND = 3'b000;
    localparam logic [2:0] CTL_OR  = 3'b001;
    localparam logic [2:0] CTL_ADD = 3'b010;
    localparam logic [2:0] CTL_SUB = 3'b110;
    localparam logic [2:0] CTL_SLT = 3'b111;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_data;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       dst_rd;
        logic       wb_mem;
        logic       reg_wr;
        logic       src_a_reg;
        logic [1:0] src_b;
        mcs_aluop_e alu_op;
        logic [1:0] pc_src;
    } mcs_strobes_t;

endpackage

// File: rtl/mcs_op_class.sv
module mcs_op_class
    import mcs_pkg::*;
#(
    parameter int               OPC_W    = 6,
    parameter logic [OPC_W-1:0] OP_REG   = 'h00,
    parameter logic [OPC_W-1:0] OP_LOAD  = 'h23,
    parameter logic [OPC_W-1:0] OP_STORE = 'h2B,
    parameter logic [OPC_W-1:0] OP_BEQ   = 'h04,
    parameter logic [OPC_W-1:0] OP_JUMP  = 'h02
) (
    input  logic [OPC_W-1:0] opcode,
    output mcs_class_e       cls
);

    always_comb begin
        if (opcode == OP_REG)        cls = CL_REG;
        else if (opcode == OP_LOAD)  cls = CL_LOAD;
        else if (opcode == OP_STORE) cls = CL_STORE;
        else if (opcode == OP_BEQ)   cls = CL_BEQ;
        else if (opcode == OP_JUMP)  cls = CL_JUMP;
        else                         cls = CL_BAD;
    end

endmodule

// File: rtl/mcs_next_state.sv
module mcs_next_state
    import mcs_pkg::*;
(
    input  mcs_state_e state,
    input  mcs_class_e cls,
    output mcs_state_e nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CL_REG:            nxt = ST_REXEC;
                    CL_LOAD, CL_STORE: nxt = ST_ADDR;
                    CL_BEQ:            nxt = ST_BRANCH;
                    CL_JUMP:           nxt = ST_JUMP;
                    default:           nxt = ST_FETCH;
                endcase
            end
            ST_ADDR:   nxt = (cls == CL_LOAD) ? ST_MEMRD : ST_MEMWR;
            ST_MEMRD:  nxt = ST_MEMWB;
            ST_REXEC:  nxt = ST_RWB;
            ST_MEMWR, ST_MEMWB, ST_RWB, ST_BRANCH, ST_JUMP:
                       nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcs_strobe_gen.sv
module mcs_strobe_gen
    import mcs_pkg::*;
(
    input  mcs_state_e   state,
    output mcs_strobes_t stb
);

    always_comb begin
        stb           = '0;
        stb.src_b     = SRCB_REG;
        stb.alu_op    = AOP_ADD;
        stb.pc_src    = PCS_ALU;
        unique case (state)
            ST_FETCH: begin
                stb.mem_rd = 1'b1;
                stb.ir_wr  = 1'b1;
                stb.pc_wr  = 1'b1;
                stb.src_b  = SRCB_FOUR;
            end
            ST_DECODE: begin
                stb.src_b = SRCB_IMM4;
            end
            ST_ADDR: begin
                stb.src_a_reg = 1'b1;
                stb.src_b     = SRCB_IMM;
            end
            ST_MEMRD: begin
                stb.mem_rd    = 1'b1;
                stb.addr_data = 1'b1;
            end
            ST_MEMWR: begin
                stb.mem_wr    = 1'b1;
                stb.addr_data = 1'b1;
            end
            ST_MEMWB: begin
                stb.reg_wr = 1'b1;
                stb.wb_mem = 1'b1;
            end
            ST_REXEC: begin
                stb.src_a_reg = 1'b1;
                stb.alu_op    = AOP_FUNC;
            end
            ST_RWB: begin
                stb.reg_wr = 1'b1;
                stb.dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                stb.src_a_reg  = 1'b1;
                stb.alu_op     = AOP_SUB;
                stb.pc_wr_cond = 1'b1;
                stb.pc_src     = PCS_AOUT;
            end
            ST_JUMP: begin
                stb.pc_wr  = 1'b1;
                stb.pc_src = PCS_JUMP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mcs_alu_ctl.sv
module mcs_alu_ctl
    import mcs_pkg::*;
#(
    parameter int FN_W = 6
) (
    input  mcs_aluop_e      alu_op,
    input  logic [FN_W-1:0] funct,
    output logic [2:0]      ctl
);

    localparam int N_FN = 5;

    function automatic logic [FN_W-1:0] fn_code(input int idx);
        case (idx)
            0:       fn_code = FN_W'(6'h20);
            1:       fn_code = FN_W'(6'h22);
            2:       fn_code = FN_W'(6'h24);
            3:       fn_code = FN_W'(6'h25);
            default: fn_code = FN_W'(6'h2A);
        endcase
    endfunction

    function automatic logic [2:0] fn_ctl(input int idx);
        case (idx)
            0:       fn_ctl = CTL_ADD;
            1:       fn_ctl = CTL_SUB;
            2:       fn_ctl = CTL_AND;
            3:       fn_ctl = CTL_OR;
            default: fn_ctl = CTL_SLT;
        endcase
    endfunction

    logic [N_FN-1:0] hit;
    logic [2:0]      fn_sel;

    for (genvar g = 0; g < N_FN; g++) begin : g_fn
        assign hit[g] = (funct == fn_code(g));
    end

    always_comb begin
        fn_sel = (hit == '0) ? CTL_ADD : 3'b000;
        for (int i = 0; i < N_FN; i++) begin
            if (hit[i]) fn_sel = fn_sel | fn_ctl(i);
        end
    end

    always_comb begin
        unique case (alu_op)
            AOP_ADD:  ctl = CTL_ADD;
            AOP_SUB:  ctl = CTL_SUB;
            AOP_FUNC: ctl = fn_sel;
            default:  ctl = CTL_ADD;
        endcase
    end

endmodule

// File: rtl/mcs_ctrl_seq.sv
module mcs_ctrl_seq
    import mcs_pkg::*;
#(
    parameter int               OPC_W    = 6,
    parameter int               FN_W     = 6,
    parameter logic [OPC_W-1:0] OP_REG   = 'h00,
    parameter logic [OPC_W-1:0] OP_LOAD  = 'h23,
    parameter logic [OPC_W-1:0] OP_STORE = 'h2B,
    parameter logic [OPC_W-1:0] OP_BEQ   = 'h04,
    parameter logic [OPC_W-1:0] OP_JUMP  = 'h02
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] ir_opcode,
    input  logic [FN_W-1:0]  ir_funct,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             addr_sel_data,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             dst_sel_rd,
    output logic             wb_sel_mem,
    output logic             reg_wr,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [2:0]       alu_ctl,
    output logic [1:0]       pc_src
);

    mcs_state_e   state;
    mcs_state_e   nxt;
    mcs_class_e   cls;
    mcs_strobes_t stb;
    logic [2:0]   ctl;

    mcs_op_class #(
        .OPC_W    (OPC_W),
        .OP_REG   (OP_REG),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE),
        .OP_BEQ   (OP_BEQ),
        .OP_JUMP  (OP_JUMP)
    ) u_class (
        .opcode (ir_opcode),
        .cls    (cls)
    );

    mcs_next_state u_next (
        .state (state),
        .cls   (cls),
        .nxt   (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    mcs_strobe_gen u_stb (
        .state (state),
        .stb   (stb)
    );

    mcs_alu_ctl #(.FN_W(FN_W)) u_alu (
        .alu_op (stb.alu_op),
        .funct  (ir_funct),
        .ctl    (ctl)
    );

    always_comb begin
        pc_wr         = stb.pc_wr      & ~rst;
        pc_wr_cond    = stb.pc_wr_cond & ~rst;
        mem_rd        = stb.mem_rd     & ~rst;
        mem_wr        = stb.mem_wr     & ~rst;
        ir_wr         = stb.ir_wr      & ~rst;
        reg_wr        = stb.reg_wr     & ~rst;
        addr_sel_data = stb.addr_data;
        dst_sel_rd    = stb.dst_rd;
        wb_sel_mem    = stb.wb_mem;
        alu_a_sel     = stb.src_a_reg;
        alu_b_sel     = stb.src_b;
        alu_ctl       = ctl;
        pc_src        = stb.pc_src;
    end

endmodule

// File: rtl/mcs_ctrl_seq_chk.sv
module mcs_ctrl_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       addr_sel_data,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       dst_sel_rd,
    input logic       wb_sel_mem,
    input logic       reg_wr,
    input logic [1:0] pc_src
);

    logic [2:0] ph;

    always_ff @(posedge clk) begin
        if (rst)             ph <= 3'd0;
        else if (ir_wr)      ph <= 3'd1;
        else if (ph != 3'd7) ph <= ph + 3'd1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |-> !(pc_wr || pc_wr_cond || mem_rd || mem_wr || ir_wr || reg_wr));

    p_fetch_port_r2: assert property (@(posedge clk) disable iff (rst)
        ir_wr |-> (mem_rd && !addr_sel_data && pc_wr));

    p_decode_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> !(pc_wr || pc_wr_cond || mem_rd || mem_wr || ir_wr || reg_wr));

    p_load_wb_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wb_sel_mem) |-> (ph == 3'd4 && !dst_sel_rd));

    p_load_end_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wb_sel_mem) |=> ir_wr);

    p_store_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (ph == 3'd3 && addr_sel_data));

    p_store_end_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);

    p_reg_wb_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !wb_sel_mem) |-> (ph == 3'd3 && dst_sel_rd));

    p_branch_r8: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |-> (ph == 3'd2 && !pc_wr && pc_src == 2'b01));

    p_jump_r9: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b10) |-> (ph == 3'd2 && !reg_wr && !mem_wr));

    p_rdwr_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

bind mcs_ctrl_seq mcs_ctrl_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .pc_wr         (pc_wr),
    .pc_wr_cond    (pc_wr_cond),
    .addr_sel_data (addr_sel_data),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .ir_wr         (ir_wr),
    .dst_sel_rd    (dst_sel_rd),
    .wb_sel_mem    (wb_sel_mem),
    .reg_wr        (reg_wr),
    .pc_src        (pc_src)
);

// File: tb/mcs_ctrl_seq_bench.sv
`timescale 1ns/1ps
module mcs_ctrl_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] ir_opcode = 6'h00;
    logic [5:0] ir_funct  = 6'h00;
    logic       pc_wr, pc_wr_cond, addr_sel_data, mem_rd, mem_wr, ir_wr;
    logic       dst_sel_rd, wb_sel_mem, reg_wr, alu_a_sel;
    logic [1:0] alu_b_sel, pc_src;
    logic [2:0] alu_ctl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    mcs_ctrl_seq u_mcs_ctrl_seq (
        .clk (clk), .rst (rst), .ir_opcode (ir_opcode), .ir_funct (ir_funct),
        .pc_wr (pc_wr), .pc_wr_cond (pc_wr_cond), .addr_sel_data (addr_sel_data),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .ir_wr (ir_wr), .dst_sel_rd (dst_sel_rd),
        .wb_sel_mem (wb_sel_mem), .reg_wr (reg_wr), .alu_a_sel (alu_a_sel),
        .alu_b_sel (alu_b_sel), .alu_ctl (alu_ctl), .pc_src (pc_src)
    );

    // vector: pc_wr,cond,addr,rd,wr,ir,dst,wb,rw,a,b[2],ctl[3],src[2]
    function automatic logic [16:0] mk(input logic pw, pc, ad, rd, wr, ir, ds, wb, rw, a,
                                       input logic [1:0] b, input logic [2:0] c,
                                       input logic [1:0] s);
        return {pw, pc, ad, rd, wr, ir, ds, wb, rw, a, b, c, s};
    endfunction

    function automatic int n_phases(input logic [5:0] op);
        case (op)
            6'h23:        return 5;
            6'h2B, 6'h00: return 4;
            6'h04, 6'h02: return 3;
            default:      return 2;
        endcase
    endfunction

    function automatic logic [2:0] exp_ctl(input logic [5:0] fn);
        case (fn)
            6'h20:   return 3'b010;
            6'h22:   return 3'b110;
            6'h24:   return 3'b000;
            6'h25:   return 3'b001;
            6'h2A:   return 3'b111;
            default: return 3'b010;
        endcase
    endfunction

    function automatic logic [16:0] exp_vec(input logic [5:0] op, input logic [5:0] fn,
                                            input int p);
        if (p == 0) return mk(1,0,0,1,0,1,0,0,0,0,2'b01,3'b010,2'b00);
        if (p == 1) return mk(0,0,0,0,0,0,0,0,0,0,2'b11,3'b010,2'b00);
        case (op)
            6'h23: begin
                if (p == 2) return mk(0,0,0,0,0,0,0,0,0,1,2'b10,3'b010,2'b00);
                if (p == 3) return mk(0,0,1,1,0,0,0,0,0,0,2'b00,3'b010,2'b00);
                return mk(0,0,0,0,0,0,0,1,1,0,2'b00,3'b010,2'b00);
            end
            6'h2B: begin
                if (p == 2) return mk(0,0,0,0,0,0,0,0,0,1,2'b10,3'b010,2'b00);
                return mk(0,0,1,0,1,0,0,0,0,0,2'b00,3'b010,2'b00);
            end
            6'h00: begin
                if (p == 2) return mk(0,0,0,0,0,0,0,0,0,1,2'b00,exp_ctl(fn),2'b00);
                return mk(0,0,0,0,0,0,1,0,1,0,2'b00,3'b010,2'b00);
            end
            6'h04:   return mk(0,1,0,0,0,0,0,0,0,1,2'b00,3'b110,2'b01);
            default: return mk(1,0,0,0,0,0,0,0,0,0,2'b00,3'b010,2'b10);
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] op, input int p);
        if (p == 0) return "R2";
        if (p == 1) return "R3";
        case (op)
            6'h23:   return "R4";
            6'h2B:   return "R5";
            6'h00:   return "R6 R7";
            6'h04:   return "R8";
            6'h02:   return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [16:0] act_vec();
        return {pc_wr, pc_wr_cond, addr_sel_data, mem_rd, mem_wr, ir_wr, dst_sel_rd,
                wb_sel_mem, reg_wr, alu_a_sel, alu_b_sel, alu_ctl, pc_src};
    endfunction

    // Precondition: called just after a negedge in a fetch cycle.
    task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input int stop_at);
        int n = n_phases(op);
        if (stop_at < n) n = stop_at;
        for (int p = 0; p < n; p++) begin
            if (p == 0) begin
                ir_opcode = op;
                ir_funct  = fn;
            end
            #1;
            n_tests++;
            if (act_vec() !== exp_vec(op, fn, p)) begin
                n_fail++;
                $display("FAIL %s op=%h fn=%h phase=%0d actual=%b expected=%b",
                         tag_of(op, p), op, fn, p, act_vec(), exp_vec(op, fn, p));
            end
            n_tests++;
            if (mem_rd && mem_wr) begin
                n_fail++;
                $display("FAIL R11 rd=%b wr=%b expected not both", mem_rd, mem_wr);
            end
            @(negedge clk);
        end
    endtask

    task automatic check_reset_quiet();
        logic [5:0] s;
        #1;
        s = {pc_wr, pc_wr_cond, mem_rd, mem_wr, ir_wr, reg_wr};
        n_tests++;
        if (s !== 6'b0) begin
            n_fail++;
            $display("FAIL R1 strobes during reset actual=%b expected=000000", s);
        end
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            check_reset_quiet();
            @(negedge clk);
        end
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [5:0] ops[6];
        logic [5:0] fns[6];
        int unused_seed;
        ops = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h02, 6'h3F};
        fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h11};
        unused_seed = $urandom(32'h5EED1234);

        @(negedge clk);
        do_reset(3);                        // R1 reset state

        // directed: each class, every funct code (R7)
        for (int k = 0; k < 6; k++) run_instr(6'h00, fns[k], 99);
        run_instr(6'h23, 6'h00, 99);         // R4
        run_instr(6'h2B, 6'h00, 99);         // R5
        run_instr(6'h04, 6'h00, 99);         // R8
        run_instr(6'h02, 6'h00, 99);         // R9
        run_instr(6'h3F, 6'h20, 99);         // R10
        run_instr(6'h05, 6'h20, 99);         // R10 near branch code
        run_instr(6'h23, 6'h00, 99);         // load right after bad opcode

        // reset in the middle of a load, then resume with fetch (R1)
        run_instr(6'h23, 6'h00, 3);
        do_reset(1);
        run_instr(6'h2B, 6'h00, 99);

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [5:0] op;
            logic [5:0] fn;
            int sel = int'($urandom_range(0, 6));
            if (sel < 6) op = ops[sel];
            else         op = 6'($urandom);
            if ($urandom_range(0, 3) == 0) fn = 6'($urandom);
            else                           fn = fns[$urandom_range(0, 4)];
            run_instr(op, fn, 99);
        end
        finish_run();
    end

endmodule